// File: doc/BRIEF.md
# Hit Stretcher and Link Framer

This block sits between 32 single-bit detector hit lines and a 4-byte-wide 8b/10b transmit port. Each hit line feeds its own pulse widener. A hit seen on a link clock edge holds that channel's bit high for a fixed number of link clocks, which corresponds to about 500 ns at the 43.75 MHz word rate of a 1.75 Gb/s lane. All 32 widened levels are sampled together. Channel i goes to bit i of one 32-bit word, so hits that coincide in a clock cycle always travel in the same word.

The word stream follows a fixed schedule. After reset a run of comma-bearing alignment words goes out, so the receiver can find word boundaries. After that the stream repeats a frame of a fixed number of words:

- an alignment word, so a receiver that has lost sync can relock and line up its parallel channels;
- a packet-start word;
- hit data words;
- a packet-end word.

The two packet markers bound the hit data for a CRC generator further down the link. The serializer, the 8b/10b encoder and the CRC generator are not part of this block.

Top module: `link_hit_framer`

## Requirements
- R1: While `rst` is high on a clock edge, the output after that edge is the alignment word: `tx_word` = 0x5AC395BC and `tx_ctrl` = 4'b0001.
- R2: Each bit of a data word is computed from the hits seen on the clock edges before it. Bit i (channel i on `hit_in[i]`) of a data word output after edge e is 1 exactly when `hit_in[i]` was high at one of the STRETCH_CYC edges e-1 down to e-STRETCH_CYC (default 22).
- R3: A hit that arrives while a channel's window is active restarts the window. The bit then stays high for STRETCH_CYC edges after the latest hit.
- R4: After reset is released, the first INIT_ALIGN output words (default 8) are alignment words.
- R5: After the initial run, the output repeats a frame of FRAME_LEN words (default 16):
  - slot 0 is an alignment word;
  - slot 1 is the packet-start word;
  - slots 2 to FRAME_LEN-2 are data words;
  - slot FRAME_LEN-1 is the packet-end word.
- R6: The words are encoded as follows. Bit k of `tx_ctrl` flags byte k (bits 8k+7:8k) as a control character.
  - Alignment word: K28.5 (0xBC) in byte 0, with `tx_ctrl` = 0001.
  - Packet-start word: 0x000000FB (K27.7 in byte 0), with `tx_ctrl` = 0001.
  - Packet-end word: 0x000000FD (K29.7 in byte 0), with `tx_ctrl` = 0001.
  - Data words: `tx_ctrl` = 0000.
- R7: Hits on several channels in the same clock cycle appear together in every data word of their common window. No bit lags another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | 32 | Hit lines, one per channel, synchronous to clk |
| tx_word | output | 32 | Word to the 8b/10b encoder, byte 0 in bits 7:0 |
| tx_ctrl | output | 4 | Per-byte control-character flag |

## Verification
A widener counter with a wrong value shows up as a data bit that drops early or lingers. This appears within STRETCH_CYC words of the hit that loaded the counter, unless the frame's marker slots hide it. A schedule counter that slips shows up at once as a marker or alignment word in a wrong slot. After that, every later frame is shifted. The bench compares every output word with a behavioural model, so either fault is reported on the first wrong word.

// File: rtl/hit_framer_pkg.sv
package hit_framer_pkg;

    localparam int NUM_CH = 32;

    localparam logic [31:0] ALIGN_WORD = 32'h5AC3_95BC;
    localparam logic [31:0] SOP_WORD   = 32'h0000_00FB;
    localparam logic [31:0] EOP_WORD   = 32'h0000_00FD;
    localparam logic [3:0]  CTRL_BYTE0 = 4'b0001;
    localparam logic [3:0]  CTRL_NONE  = 4'b0000;

    typedef enum logic [1:0] {
        SLOT_ALIGN,
        SLOT_SOP,
        SLOT_DATA,
        SLOT_EOP
    } slot_kind_t;

    typedef struct packed {
        logic [31:0] data;
        logic [3:0]  ctrl;
    } link_word_t;

    function automatic link_word_t make_word(slot_kind_t kind, logic [NUM_CH-1:0] hits);
        link_word_t w;
        case (kind)
            SLOT_SOP:  begin w.data = SOP_WORD;   w.ctrl = CTRL_BYTE0; end
            SLOT_EOP:  begin w.data = EOP_WORD;   w.ctrl = CTRL_BYTE0; end
            SLOT_DATA: begin w.data = hits;       w.ctrl = CTRL_NONE;  end
            default:   begin w.data = ALIGN_WORD; w.ctrl = CTRL_BYTE0; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/hit_stretch_lane.sv
module hit_stretch_lane #(
    parameter int STRETCH_CYC = 22
) (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic level
);
    localparam int CW = $clog2(STRETCH_CYC + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (hit)
            remain <= CW'(STRETCH_CYC);
        else if (remain != '0)
            remain <= remain - CW'(1);
    end

    assign level = (remain != '0);

    // R2
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> level);

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import hit_framer_pkg::*;
#(
    parameter int INIT_ALIGN = 8,
    parameter int FRAME_LEN  = 16
) (
    input  logic       clk,
    input  logic       rst,
    output slot_kind_t kind
);
    localparam int IW = $clog2(INIT_ALIGN + 1);
    localparam int SW = $clog2(FRAME_LEN);

    typedef enum logic {SEQ_INIT, SEQ_RUN} seq_state_t;

    seq_state_t    state;
    logic [IW-1:0] init_cnt;
    logic [SW-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_INIT;
            init_cnt <= '0;
            slot     <= '0;
        end else begin
            case (state)
                SEQ_INIT: begin
                    if (init_cnt == IW'(INIT_ALIGN - 1))
                        state <= SEQ_RUN;
                    else
                        init_cnt <= init_cnt + IW'(1);
                end
                default: begin
                    if (slot == SW'(FRAME_LEN - 1))
                        slot <= '0;
                    else
                        slot <= slot + SW'(1);
                end
            endcase
        end
    end

    always_comb begin
        if (state == SEQ_INIT)
            kind = SLOT_ALIGN;
        else if (slot == '0)
            kind = SLOT_ALIGN;
        else if (slot == SW'(1))
            kind = SLOT_SOP;
        else if (slot == SW'(FRAME_LEN - 1))
            kind = SLOT_EOP;
        else
            kind = SLOT_DATA;
    end

    // R5
    seq_sop_after_align_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == SLOT_SOP) |=> (kind == SLOT_DATA));

endmodule

// File: rtl/link_hit_framer.sv
module link_hit_framer
    import hit_framer_pkg::*;
#(
    parameter int STRETCH_CYC = 22,
    parameter int INIT_ALIGN  = 8,
    parameter int FRAME_LEN   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] hit_in,
    output logic [31:0] tx_word,
    output logic [3:0]  tx_ctrl
);
    logic [NUM_CH-1:0] stretched;
    slot_kind_t        kind;
    link_word_t        out_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        hit_stretch_lane #(.STRETCH_CYC(STRETCH_CYC)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .hit   (hit_in[ch]),
            .level (stretched[ch])
        );
    end

    frame_sequencer #(
        .INIT_ALIGN (INIT_ALIGN),
        .FRAME_LEN  (FRAME_LEN)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .kind (kind)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= make_word(SLOT_ALIGN, '0);
        else
            out_q <= make_word(kind, stretched);
    end

    assign tx_word = out_q.data;
    assign tx_ctrl = out_q.ctrl;

    // R6
    ctrl_byte0_only_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ctrl[3:1] == 3'b000);

    // R5
    sop_then_data_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ctrl == 4'b0001 && tx_word == 32'h0000_00FB) |=> (tx_ctrl == 4'b0000));

    // R5
    eop_then_align_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ctrl == 4'b0001 && tx_word == 32'h0000_00FD) |=> (tx_word == 32'h5AC3_95BC));

endmodule

// File: tb/link_hit_framer_test.sv
module link_hit_framer_test;
    localparam int S_CYC = 22;
    localparam int INIT  = 8;
    localparam int FLEN  = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] hit_in = '0;
    logic [31:0] tx_word;
    logic [3:0]  tx_ctrl;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int          rem [32];
    int          edge_n = 0;
    logic [31:0] exp_word;
    logic [3:0]  exp_ctrl;
    string       exp_tag = "R1";
    bit          model_ok = 0;

    always #2 clk = ~clk;

    link_hit_framer #(.STRETCH_CYC(S_CYC), .INIT_ALIGN(INIT), .FRAME_LEN(FLEN)) uut (
        .clk(clk), .rst(rst), .hit_in(hit_in), .tx_word(tx_word), .tx_ctrl(tx_ctrl)
    );

    // Reference model: expected word after each edge
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) rem[i] = 0;
            edge_n   = 0;
            exp_word = 32'h5AC3_95BC;
            exp_ctrl = 4'b0001;
            exp_tag  = "R1";
        end else begin
            edge_n++;
            if (edge_n <= INIT) begin
                exp_word = 32'h5AC3_95BC; exp_ctrl = 4'b0001; exp_tag = "R4 R6";
            end else begin
                int pos;
                pos = (edge_n - INIT - 1) % FLEN;
                if (pos == 0) begin
                    exp_word = 32'h5AC3_95BC; exp_ctrl = 4'b0001; exp_tag = "R5 R6";
                end else if (pos == 1) begin
                    exp_word = 32'h0000_00FB; exp_ctrl = 4'b0001; exp_tag = "R5 R6";
                end else if (pos == FLEN - 1) begin
                    exp_word = 32'h0000_00FD; exp_ctrl = 4'b0001; exp_tag = "R5 R6";
                end else begin
                    for (int i = 0; i < 32; i++) exp_word[i] = (rem[i] > 0);
                    exp_ctrl = 4'b0000; exp_tag = "R2 R3 R7";
                end
            end
            for (int i = 0; i < 32; i++) begin
                if (hit_in[i]) rem[i] = S_CYC;
                else if (rem[i] > 0) rem[i]--;
            end
        end
        model_ok = 1;
    end

    always @(negedge clk) begin
        if (model_ok && !done) begin
            checks++;
            if (tx_word !== exp_word || tx_ctrl !== exp_ctrl) begin
                failures++;
                $display("FAIL %s edge=%0d actual=%h/%b expected=%h/%b",
                         exp_tag, edge_n, tx_word, tx_ctrl, exp_word, exp_ctrl);
            end
        end
    end

    task automatic drive(input logic [31:0] mask, input int len);
        @(negedge clk) hit_in = mask;
        repeat (len) @(negedge clk);
        hit_in = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(5);
        // R2: isolated one-cycle pulse on channel 0
        drive(32'h0000_0001, 1);
        idle(40);
        // R3: retrigger channel 5 inside its window
        drive(32'h0000_0020, 1);
        idle(9);
        drive(32'h0000_0020, 1);
        idle(45);
        // R7: several channels in the same cycle
        drive(32'h8001_8421, 1);
        idle(40);
        // R2: held level on channel 31
        drive(32'h8000_0000, 30);
        idle(40);
        // walking bit, one per cycle
        for (int b = 0; b < 32; b++) drive(32'h1 << b, 1);
        idle(40);
        // pseudo-random hits
        for (int n = 0; n < 300; n++) drive($urandom() & $urandom(), 1);
        idle(40);
        // R1 R4: reset mid-run, then restart schedule
        @(negedge clk) rst = 1'b1;
        hit_in = 32'hFFFF_FFFF;
        idle(3);
        hit_in = '0;
        rst = 1'b0;
        idle(12);
        drive(32'h00F0_0F00, 2);
        idle(60);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule